// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A cluster-level event counting block. Up to 31 event counters of 32 bits, set by a parameter, and one free-running 64-bit cycle counter sit behind a small word-addressed register port. Each event counter has a select register that picks one of 64 event lines. Lines are sampled one level per clock, and the counter advances by one for each clock in which its line is high. Counting is gated by a global enable and by a per-counter enable mask. All per-counter masks share one bit-index space: bit n is event counter n and bit 31 is the cycle counter.

A counter that wraps from all-ones to zero latches a bit in the overflow status register. Software reads that register once. The read returns the latched bits and clears them in the same cycle. An overflow that lands in the cycle of the read is held for the following read. A level interrupt is high while any latched overflow has its interrupt-enable bit set. Software preloads counters by writing them directly, for example to half scale, so that an interrupt arrives after a known number of events.

Top module: `perf_mon_unit`

## Requirements
- R1: Enable mask (0x01), interrupt-enable mask (0x02) and overflow status (0x03) use bit n for event counter n (n < NUM_CTRS) and bit 31 for the cycle counter. Bits of counters that do not exist always read 0.
- R2: Control register 0x00 reads as {impl code[31:24], id code[23:16], NUM_CTRS[15:11], zeros[10:1], global enable[0]}. Bit 0 is read/write. Bits 1 and 2 are write-only triggers that read 0.
- R3: Event counter n (value at 0x20+n) increments by one on each clock in which the line selected by its 6-bit select register (0x40+n, readable) is high, provided the global enable and mask bit n are both set. Otherwise it holds its value.
- R4: Select codes 0x11 (cycles) and 0x1e (chain) never advance an event counter. Any other code counts its line.
- R5: The 64-bit cycle counter (low word 0x06, high word 0x07) increments on every clock while the global enable and mask bit 31 are set, with carry from the low word into the high word.
- R6: A write to a counter word loads it. The write takes priority over an increment in the same clock, and counting resumes from the loaded value.
- R7: A control write with bit 1 set clears every event counter, and one with bit 2 set clears the cycle counter. Neither clears the other kind.
- R8: A counter that wraps from all-ones to zero sets its overflow status bit.
- R9: Reading 0x03 returns the latched overflow bits and clears them. A wrap in the same clock as that read stays latched and appears on the next read.
- R10: irq is high exactly while some overflow bit is set whose interrupt-enable bit is also set.
- R11: 0x04 and 0x05 return the low and high 32 bits of the event-availability parameter (bit k means code k exists).
- R12: Read data appears on rdata in the clock after rd_en. Addresses that are not mapped, including those of counters that do not exist, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| evt_in | input | 64 | Event lines, one per event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
A wrong counter value shows on the next read of that counter, one clock after the read strobe. It can also show later as a wrap that comes early or late, which moves the overflow status bit and irq by the same number of clocks. Errors in the overflow register are the hardest to see. A bit that is cleared without being read, or a wrap that is lost at a clearing read, only shows at the next status read or as irq staying low. For that reason the bench places a wrap in exactly the clock of a read and reads the status twice. A counter that steps while disabled shows on its next read as a count larger than the number of enabled clocks.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int REG_W        = 32;
   localparam int ADDR_W       = 7;
   localparam int EVT_LINES    = 64;
   localparam int SEL_W        = $clog2(EVT_LINES);
   localparam int CYC_BIT      = 31;
   localparam int MAX_EVT_CTRS = 31;

   // control register layout
   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_EVRST_BIT = 1;
   localparam int CTRL_CYRST_BIT = 2;

   // register addresses
   localparam logic [ADDR_W-1:0] A_CTRL   = 7'h00;
   localparam logic [ADDR_W-1:0] A_CNTEN  = 7'h01;
   localparam logic [ADDR_W-1:0] A_INTEN  = 7'h02;
   localparam logic [ADDR_W-1:0] A_OVF    = 7'h03;
   localparam logic [ADDR_W-1:0] A_AVL_LO = 7'h04;
   localparam logic [ADDR_W-1:0] A_AVL_HI = 7'h05;
   localparam logic [ADDR_W-1:0] A_CYC_LO = 7'h06;
   localparam logic [ADDR_W-1:0] A_CYC_HI = 7'h07;
   localparam int A_CNT_BASE = 'h20;
   localparam int A_SEL_BASE = 'h40;

   // event codes that an event counter never serves
   localparam logic [SEL_W-1:0] EVT_CYCLES = 6'h11;
   localparam logic [SEL_W-1:0] EVT_CHAIN  = 6'h1e;

   function automatic logic evt_reserved(input logic [SEL_W-1:0] code);
      return (code == EVT_CYCLES) || (code == EVT_CHAIN);
   endfunction

   function automatic logic [REG_W-1:0] impl_mask(input int n);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_EVT_CTRS; i++)
         if (i < n) m[i] = 1'b1;
      m[CYC_BIT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr import pmu_pkg::*; #(
   parameter int W     = 32,
   parameter int LINES = 64,
   parameter int SW    = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [LINES-1:0] lines,
   input  logic [SW-1:0]    sel,
   input  logic             clr,
   input  logic             wr,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     value,
   output logic             wrap
);
   if (LINES != (1 << SW)) begin : g_bad_sel
      $error("pmu_evt_ctr: select width does not cover the event lines");
   end

   logic hit;
   assign hit  = run && lines[sel] && !evt_reserved(sel);
   assign wrap = hit && !clr && !wr && (&value);

   always_ff @(posedge clk) begin
      if (!rst_n)      value <= '0;
      else if (clr)    value <= '0;
      else if (wr)     value <= wdata;
      else if (hit)    value <= value + 1'b1;
   end
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
   parameter int W = 64
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           clr,
   input  logic           wr_lo,
   input  logic           wr_hi,
   input  logic [W/2-1:0] wdata,
   output logic [W-1:0]   value,
   output logic           wrap
);
   localparam int HALF = W / 2;

   if (W % 2 != 0) begin : g_bad_width
      $error("pmu_cyc_ctr: width must be even");
   end

   assign wrap = run && !clr && !wr_lo && !wr_hi && (&value);

   always_ff @(posedge clk) begin
      if (!rst_n)              value <= '0;
      else if (clr)            value <= '0;
      else if (wr_lo || wr_hi) value <= {wr_hi ? wdata : value[W-1:HALF],
                                         wr_lo ? wdata : value[HALF-1:0]};
      else if (run)            value <= value + 1'b1;
   end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit import pmu_pkg::*; #(
   parameter int          NUM_CTRS  = 4,
   parameter logic [7:0]  ID_CODE   = 8'h5A,
   parameter logic [7:0]  IMPL_CODE = 8'hC3,
   parameter logic [63:0] EVT_AVAIL = 64'h0000_3C00_2E0A_0001
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   input  logic [EVT_LINES-1:0] evt_in,
   output logic                 irq
);
   localparam logic [REG_W-1:0] IMPL_MASK = impl_mask(NUM_CTRS);
   localparam logic [4:0]       N_FIELD   = 5'(NUM_CTRS);

   if (NUM_CTRS < 1 || NUM_CTRS > MAX_EVT_CTRS) begin : g_bad_cfg
      $error("perf_mon_unit: NUM_CTRS out of range");
   end

   logic             glob_en_q;
   logic [REG_W-1:0] cnten_q, inten_q, ovf_q, rdata_q, rd_mux, wrap_vec;
   logic [SEL_W-1:0] sel_q   [NUM_CTRS];
   logic [REG_W-1:0] evt_val [NUM_CTRS];
   logic [NUM_CTRS-1:0] evt_wrap;
   logic [63:0]      cyc_val;
   logic             cyc_wrap;

   logic wr_ctrl, wr_cnten, wr_inten, ovf_rd, cyc_wr_lo, cyc_wr_hi, cyc_wr_any;
   logic ev_clr, cy_clr;

   assign wr_ctrl    = wr_en && (addr == A_CTRL);
   assign wr_cnten   = wr_en && (addr == A_CNTEN);
   assign wr_inten   = wr_en && (addr == A_INTEN);
   assign cyc_wr_lo  = wr_en && (addr == A_CYC_LO);
   assign cyc_wr_hi  = wr_en && (addr == A_CYC_HI);
   assign cyc_wr_any = cyc_wr_lo || cyc_wr_hi;
   assign ovf_rd     = rd_en && (addr == A_OVF);
   assign ev_clr     = wr_ctrl && wdata[CTRL_EVRST_BIT];
   assign cy_clr     = wr_ctrl && wdata[CTRL_CYRST_BIT];

   for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
      localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(A_CNT_BASE + i);
      localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(A_SEL_BASE + i);

      always_ff @(posedge clk) begin
         if (!rst_n)                        sel_q[i] <= '0;
         else if (wr_en && addr == SEL_A)   sel_q[i] <= wdata[SEL_W-1:0];
      end

      pmu_evt_ctr #(.W(REG_W), .LINES(EVT_LINES), .SW(SEL_W)) ctr_i (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (glob_en_q && cnten_q[i]),
         .lines (evt_in),
         .sel   (sel_q[i]),
         .clr   (ev_clr),
         .wr    (wr_en && addr == CNT_A),
         .wdata (wdata),
         .value (evt_val[i]),
         .wrap  (evt_wrap[i])
      );
   end

   pmu_cyc_ctr #(.W(64)) cyc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (glob_en_q && cnten_q[CYC_BIT]),
      .clr   (cy_clr),
      .wr_lo (cyc_wr_lo),
      .wr_hi (cyc_wr_hi),
      .wdata (wdata),
      .value (cyc_val),
      .wrap  (cyc_wrap)
   );

   always_comb begin
      wrap_vec = '0;
      for (int i = 0; i < NUM_CTRS; i++) wrap_vec[i] = evt_wrap[i];
      wrap_vec[CYC_BIT] = cyc_wrap;
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         A_CTRL:   rd_mux = {IMPL_CODE, ID_CODE, N_FIELD, 10'b0, glob_en_q};
         A_CNTEN:  rd_mux = cnten_q;
         A_INTEN:  rd_mux = inten_q;
         A_OVF:    rd_mux = ovf_q;
         A_AVL_LO: rd_mux = EVT_AVAIL[31:0];
         A_AVL_HI: rd_mux = EVT_AVAIL[63:32];
         A_CYC_LO: rd_mux = cyc_val[31:0];
         A_CYC_HI: rd_mux = cyc_val[63:32];
         default: begin
            for (int i = 0; i < NUM_CTRS; i++) begin
               if (addr == ADDR_W'(A_CNT_BASE + i)) rd_mux = evt_val[i];
               if (addr == ADDR_W'(A_SEL_BASE + i)) rd_mux = REG_W'(sel_q[i]);
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en_q <= 1'b0;
         cnten_q   <= '0;
         inten_q   <= '0;
         ovf_q     <= '0;
         rdata_q   <= '0;
      end else begin
         if (wr_ctrl)  glob_en_q <= wdata[CTRL_EN_BIT];
         if (wr_cnten) cnten_q   <= wdata & IMPL_MASK;
         if (wr_inten) inten_q   <= wdata & IMPL_MASK;
         ovf_q <= (ovf_rd ? '0 : ovf_q) | wrap_vec;
         if (rd_en)    rdata_q   <= rd_mux;
      end
   end

   assign rdata = rdata_q;
   assign irq   = |(ovf_q & inten_q);
endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk #(
   parameter int NUM_CTRS = 4
)(
   input logic        clk,
   input logic        rst_n,
   input logic        irq,
   input logic        ovf_rd,
   input logic        glob_en_q,
   input logic        cyc_wr_any,
   input logic        cy_clr,
   input logic [31:0] ovf_q,
   input logic [31:0] inten_q,
   input logic [31:0] cnten_q,
   input logic [31:0] wrap_vec,
   input logic [63:0] cyc_val
);
   localparam logic [31:0] IMPL_MASK = pmu_pkg::impl_mask(NUM_CTRS);

   assert_unimpl_ovf_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q & ~IMPL_MASK) == 32'd0);

   assert_cyc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en_q && !cyc_wr_any && !cy_clr) |=> $stable(cyc_val));

   assert_cyc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_en_q && cnten_q[31] && !cyc_wr_any && !cy_clr) |=> (cyc_val == $past(cyc_val) + 64'd1));

   assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_rd && wrap_vec == 32'd0) |=> (ovf_q == 32'd0));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_rd |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

   assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(|wrap_vec) || !$stable(inten_q)));
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.NUM_CTRS(NUM_CTRS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .ovf_rd     (ovf_rd),
   .glob_en_q  (glob_en_q),
   .cyc_wr_any (cyc_wr_any),
   .cy_clr     (cy_clr),
   .ovf_q      (ovf_q),
   .inten_q    (inten_q),
   .cnten_q    (cnten_q),
   .wrap_vec   (wrap_vec),
   .cyc_val    (cyc_val)
);

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          N          = 4;
   localparam logic [63:0] AVAIL      = 64'h0123_4567_89AB_CDEF;
   localparam logic [6:0]  R_CTRL = 7'h00, R_CNTEN = 7'h01, R_INTEN = 7'h02, R_OVF = 7'h03;
   localparam logic [6:0]  R_AVL_LO = 7'h04, R_AVL_HI = 7'h05, R_CYC_LO = 7'h06, R_CYC_HI = 7'h07;
   localparam logic [6:0]  R_CNT = 7'h20, R_SEL = 7'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] evt_in = '0;
   logic        irq;
   int          total = 0, bad = 0;
   bit          done = 1'b0;
   logic [31:0] v;

   always #(CLK_PERIOD/2) clk = ~clk;

   perf_mon_unit #(.NUM_CTRS(N), .ID_CODE(8'h5A), .IMPL_CODE(8'hC3), .EVT_AVAIL(AVAIL)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   // enabled for k+1 rising edges
   task automatic run_window(input int k);
      wr(R_CTRL, 32'h1);
      repeat (k) @(negedge clk);
      wr(R_CTRL, 32'h0);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(R_CTRL, v);  chk("R2 reset ctrl", v, 32'hC35A_2000);
      chk("R10 reset irq", irq, 0);
      rd(R_OVF, v);   chk("R9 reset ovf", v, 0);
      rd(R_CNTEN, v); chk("R1 reset cnten", v, 0);

      wr(R_CTRL, 32'h7);
      rd(R_CTRL, v);  chk("R2 ctrl enable bit", v, 32'hC35A_2001);
      wr(R_CTRL, 32'h0);

      wr(R_CNTEN, 32'hFFFF_FFFF); rd(R_CNTEN, v); chk("R1 cnten mask", v, 32'h8000_000F);
      wr(R_INTEN, 32'hFFFF_FFFF); rd(R_INTEN, v); chk("R1 inten mask", v, 32'h8000_000F);
      wr(R_CNTEN, 0); wr(R_INTEN, 0);

      rd(R_AVL_LO, v); chk("R11 avail low", v, AVAIL[31:0]);
      rd(R_AVL_HI, v); chk("R11 avail high", v, AVAIL[63:32]);

      rd(7'h10, v);     chk("R12 unmapped", v, 0);
      rd(R_CNT + 5, v); chk("R12 absent counter", v, 0);
      rd(R_SEL + 6, v); chk("R12 absent select", v, 0);

      // sweep every select code on counter 0 with all lines high
      wr(R_CNTEN, 32'h1);
      evt_in = '1;
      for (int code = 0; code < 64; code++) begin
         wr(R_CTRL, 32'h2);
         wr(R_SEL, 32'(code));
         rd(R_SEL, v); chk("R3 select readback", v, 32'(code));
         run_window(2);
         rd(R_CNT, v);
         chk("R4 code sweep count", v, (code == 'h11 || code == 'h1e) ? 0 : 3);
      end
      evt_in = '0;

      // one-hot line patterns on counters 1..3
      wr(R_SEL + 1, 3); wr(R_SEL + 2, 40); wr(R_SEL + 3, 63);
      wr(R_CNTEN, 32'hE);
      for (int p = 0; p < 3; p++) begin
         int line;
         line = (p == 0) ? 3 : (p == 1) ? 40 : 63;
         wr(R_CTRL, 32'h2);
         evt_in = 64'd1 << line;
         run_window(4);
         evt_in = '0;
         for (int c = 1; c <= 3; c++) begin
            rd(R_CNT + 7'(c), v);
            chk("R3 line select", v, (c == p + 1) ? 5 : 0);
         end
         rd(R_CNT, v); chk("R3 disabled counter holds", v, 0);
      end

      // preload, wrap, overflow, irq
      wr(R_CTRL, 32'h2);
      wr(R_SEL, 5); wr(R_CNTEN, 32'h1); wr(R_INTEN, 32'h1);
      wr(R_CNT, 32'hFFFF_FFFE);
      rd(R_CNT, v); chk("R6 preload", v, 32'hFFFF_FFFE);
      evt_in = 64'd1 << 5;
      run_window(2);
      evt_in = '0;
      rd(R_CNT, v); chk("R6 count from preload", v, 1);
      chk("R10 irq on overflow", irq, 1);
      rd(R_OVF, v); chk("R8 ovf bit0", v, 32'h1);
      chk("R10 irq after clear", irq, 0);
      rd(R_OVF, v); chk("R9 cleared by read", v, 0);

      // masked interrupt
      wr(R_INTEN, 0);
      wr(R_CNT, 32'hFFFF_FFFF);
      evt_in = 64'd1 << 5;
      run_window(0);
      evt_in = '0;
      chk("R10 masked irq", irq, 0);
      wr(R_INTEN, 1);
      chk("R10 unmasked irq", irq, 1);
      rd(R_OVF, v); chk("R8 masked wrap latched", v, 32'h1);

      // wrap in the same clock as the clearing read
      wr(R_CTRL, 32'h1);
      wr(R_CNT, 32'hFFFF_FFFF);
      evt_in = 64'd1 << 5;
      rd(R_OVF, v);
      evt_in = '0;
      chk("R9 read during wrap", v, 0);
      wr(R_CTRL, 32'h0);
      rd(R_OVF, v); chk("R9 wrap kept", v, 32'h1);
      wr(R_INTEN, 0);

      // cycle counter
      wr(R_CTRL, 32'h4);
      wr(R_CNTEN, 32'h8000_0000);
      run_window(6);
      rd(R_CYC_LO, v); chk("R5 cycle low", v, 7);
      rd(R_CYC_HI, v); chk("R5 cycle high", v, 0);
      wr(R_CNTEN, 0);
      run_window(3);
      rd(R_CYC_LO, v); chk("R5 cycle disabled", v, 7);

      wr(R_CYC_LO, 32'hFFFF_FFFF); wr(R_CYC_HI, 32'hFFFF_FFFF);
      rd(R_CYC_HI, v); chk("R6 cycle preload high", v, 32'hFFFF_FFFF);
      wr(R_CNTEN, 32'h8000_0000);
      run_window(1);
      rd(R_CYC_LO, v); chk("R8 cycle after wrap low", v, 1);
      rd(R_CYC_HI, v); chk("R8 cycle after wrap high", v, 0);
      rd(R_OVF, v);    chk("R8 cycle ovf bit31", v, 32'h8000_0000);

      wr(R_CYC_LO, 32'hFFFF_FFFF); wr(R_CYC_HI, 0);
      run_window(0);
      rd(R_CYC_HI, v); chk("R5 carry high", v, 1);
      rd(R_CYC_LO, v); chk("R5 carry low", v, 0);
      rd(R_OVF, v);    chk("R8 no false ovf", v, 0);

      // counter resets
      wr(R_CNT, 123); wr(R_CNT + 2, 77); wr(R_CYC_LO, 55);
      wr(R_CTRL, 32'h2);
      rd(R_CNT, v);     chk("R7 event reset c0", v, 0);
      rd(R_CNT + 2, v); chk("R7 event reset c2", v, 0);
      rd(R_CYC_LO, v);  chk("R7 cycle kept", v, 55);
      wr(R_CNT + 1, 9);
      wr(R_CTRL, 32'h4);
      rd(R_CYC_LO, v);  chk("R7 cycle reset", v, 0);
      rd(R_CNT + 1, v); chk("R7 event kept", v, 9);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule